// File: doc/BRIEF.md
# Prescaled Down-Counting Timer

This block is a general-purpose timer made of an 8-bit down-counter driven through a 7-bit down-counting prescaler. A fixed divider turns the system clock into a one-cycle advance pulse every twelve clocks, and that pulse steps the prescaler. A three-bit tap code chooses what advances the counter. It can be the raw advance pulse, or the rising edge of one prescaler bit. This gives a division of 2^code, from 1 to 128. The longest interval is 2^15 advance pulses.

Software reaches the timer over a small address/data bus. The registers are the counter, the prescaler and one control/status byte. The control/status byte holds the zero flag, the interrupt enable, the run bit and the tap code. When the counter steps from one to zero, the zero flag is set. While the flag and the enable are both one, an interrupt request is raised. Clearing the run bit parks the prescaler at all ones and stops the counter.

Top module: `prescaled_timer`

## Requirements
- R1: After reset the counter reads 0xFF, the prescaler reads 0x7F, the control/status byte reads 0x00 and irq is low.
- R2: While running, the prescaler drops by exactly one on each advance pulse, and advance pulses come every 12 clocks.
- R3: Tap code n (control bits 2:0) makes the counter drop by one per 2^n advance pulses. Code 0 uses the advance pulse itself; code n>0 uses the rising edge of prescaler bit n-1.
- R4: A counter step from 1 to 0 sets the zero flag (control bit 7). A step from 0 wraps the counter to 0xFF and does not set the flag.
- R5: irq is high exactly while the zero flag and the interrupt enable (control bit 6) are both one.
- R6: While the run bit (control bit 5) is zero, the prescaler reads 0x7F, prescaler writes are ignored, and the counter holds its value but can still be loaded.
- R7: While the run bit is one, a write to the prescaler loads any value from 0x00 to 0x7F.
- R8: A counter write in the same cycle as a counter step wins: the written value is stored.
- R9: The zero flag stays set until software writes it. A software write to the flag in the same cycle as a hardware set wins.
- R10: Address 0 is the counter, 1 the prescaler, 2 the control/status byte (bits 4:3 read 0), and 3 reads 0. Read data appears on bus_rdata the cycle after the read and is held until the next read.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| bus_sel | input | 1 | Bus access strobe for one cycle |
| bus_wr | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 2 | Register select |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Registered read data |
| irq | output | 1 | Interrupt request, level |

## Verification
The bench builds the block with its default parameters: a divide-by-12 advance, 8-bit counter, 7-bit prescaler and 3-bit tap code. With these values the real advance cadence can be measured. It runs tap codes 0, 2 and 7, and a wrong tap bit moves the time to interrupt out of its allowed window. The bench learns the advance phase from the first interrupt. It can then place writes exactly on a counter step, which exercises the write-over-step and flag-clear-over-set priorities.

// File: rtl/tmr_pkg.sv
package tmr_pkg;
  localparam logic [1:0] ADDR_CNT  = 2'd0;
  localparam logic [1:0] ADDR_PSC  = 2'd1;
  localparam logic [1:0] ADDR_CTRL = 2'd2;
  localparam int ZF_BIT  = 7;
  localparam int IE_BIT  = 6;
  localparam int RUN_BIT = 5;
endpackage

// File: rtl/tmr_rst_sync.sv
module tmr_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= 2'b00;
    else        sync_q <= {sync_q[0], 1'b1};
  end

  assign rst_sync_n = sync_q[1];
endmodule

// File: rtl/tmr_clk_div.sv
module tmr_clk_div #(
  parameter int DIV = 12
) (
  input  logic clk,
  input  logic rst_n,
  output logic adv
);
  localparam int DW = (DIV > 1) ? $clog2(DIV) : 1;
  localparam logic [DW-1:0] LAST = DW'(DIV - 1);

  logic [DW-1:0] div_q, div_d;

  always_comb begin
    div_d = (div_q == LAST) ? '0 : div_q + 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) div_q <= '0;
    else        div_q <= div_d;
  end

  assign adv = (div_q == LAST);
endmodule

// File: rtl/tmr_prescaler.sv
module tmr_prescaler #(
  parameter int PSC_W = 7,
  parameter int SEL_W = 3
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             adv,
  input  logic             run,
  input  logic             wr_en,
  input  logic [PSC_W-1:0] wr_data,
  input  logic [SEL_W-1:0] sel,
  output logic [PSC_W-1:0] psc,
  output logic             step
);
  localparam int NTAP = 2 ** SEL_W;

  logic [PSC_W-1:0] psc_q, psc_d;
  logic [NTAP-1:0]  tap_vec;
  logic             tap_lvl, tap_q;

  assign tap_vec[0] = 1'b0;
  genvar g;
  generate
    for (g = 1; g < NTAP; g++) begin : g_tap
      if (g <= PSC_W) begin : g_bit
        assign tap_vec[g] = psc_q[g-1];
      end else begin : g_none
        assign tap_vec[g] = 1'b0;
      end
    end
  endgenerate

  assign tap_lvl = tap_vec[sel];

  always_comb begin
    psc_d = psc_q;
    if (!run)       psc_d = '1;
    else if (wr_en) psc_d = wr_data;
    else if (adv)   psc_d = psc_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      psc_q <= '1;
      tap_q <= 1'b1;
    end else begin
      psc_q <= psc_d;
      tap_q <= tap_lvl;
    end
  end

  assign step = run & ((sel == '0) ? adv : (tap_lvl & ~tap_q));
  assign psc  = psc_q;
endmodule

// File: rtl/tmr_counter.sv
module tmr_counter #(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             step,
  input  logic             wr_en,
  input  logic [CNT_W-1:0] wr_data,
  output logic [CNT_W-1:0] cnt,
  output logic             hit_zero
);
  localparam logic [CNT_W-1:0] ONE = CNT_W'(1);

  logic [CNT_W-1:0] cnt_q, cnt_d;

  always_comb begin
    cnt_d = cnt_q;
    if (wr_en)     cnt_d = wr_data;
    else if (step) cnt_d = cnt_q - 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt_q <= '1;
    else        cnt_q <= cnt_d;
  end

  assign hit_zero = step & ~wr_en & (cnt_q == ONE);
  assign cnt      = cnt_q;
endmodule

// File: rtl/prescaled_timer.sv
module prescaled_timer
  import tmr_pkg::*;
#(
  parameter int DIV    = 12,
  parameter int CNT_W  = 8,
  parameter int PSC_W  = 7,
  parameter int SEL_W  = 3,
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_sel,
  input  logic              bus_wr,
  input  logic [1:0]        bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] bus_rdata,
  output logic              irq
);
  logic             rst_sync_n;
  logic             adv, step, hit_zero;
  logic             cnt_wr, psc_wr, ctrl_wr, rd_en;
  logic [CNT_W-1:0] cnt_q;
  logic [PSC_W-1:0] psc_q;
  logic             zf_q, zf_d, ie_q, ie_d, run_q, run_d;
  logic [SEL_W-1:0] sel_q, sel_d;
  logic [DATA_W-1:0] rdata_q, rdata_d, ctrl_rd;

  tmr_rst_sync u_rst (.clk(clk), .rst_n(rst_n), .rst_sync_n(rst_sync_n));

  tmr_clk_div #(.DIV(DIV)) u_div (.clk(clk), .rst_n(rst_sync_n), .adv(adv));

  assign rd_en   = bus_sel & ~bus_wr;
  assign cnt_wr  = bus_sel & bus_wr & (bus_addr == ADDR_CNT);
  assign psc_wr  = bus_sel & bus_wr & (bus_addr == ADDR_PSC);
  assign ctrl_wr = bus_sel & bus_wr & (bus_addr == ADDR_CTRL);

  tmr_prescaler #(.PSC_W(PSC_W), .SEL_W(SEL_W)) u_psc (
    .clk(clk), .rst_n(rst_sync_n), .adv(adv), .run(run_q),
    .wr_en(psc_wr), .wr_data(bus_wdata[PSC_W-1:0]), .sel(sel_q),
    .psc(psc_q), .step(step)
  );

  tmr_counter #(.CNT_W(CNT_W)) u_cnt (
    .clk(clk), .rst_n(rst_sync_n), .step(step), .wr_en(cnt_wr),
    .wr_data(bus_wdata[CNT_W-1:0]), .cnt(cnt_q), .hit_zero(hit_zero)
  );

  // control/status next state: software write beats hardware set
  always_comb begin
    zf_d  = zf_q;
    ie_d  = ie_q;
    run_d = run_q;
    sel_d = sel_q;
    if (ctrl_wr) begin
      zf_d  = bus_wdata[ZF_BIT];
      ie_d  = bus_wdata[IE_BIT];
      run_d = bus_wdata[RUN_BIT];
      sel_d = bus_wdata[SEL_W-1:0];
    end else if (hit_zero) begin
      zf_d  = 1'b1;
    end
  end

  always_comb begin
    ctrl_rd          = '0;
    ctrl_rd[ZF_BIT]  = zf_q;
    ctrl_rd[IE_BIT]  = ie_q;
    ctrl_rd[RUN_BIT] = run_q;
    ctrl_rd[SEL_W-1:0] = sel_q;
  end

  always_comb begin
    rdata_d = rdata_q;
    if (rd_en) begin
      case (bus_addr)
        ADDR_CNT:  rdata_d = DATA_W'(cnt_q);
        ADDR_PSC:  rdata_d = DATA_W'(psc_q);
        ADDR_CTRL: rdata_d = ctrl_rd;
        default:   rdata_d = '0;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n) begin
      zf_q    <= 1'b0;
      ie_q    <= 1'b0;
      run_q   <= 1'b0;
      sel_q   <= '0;
      rdata_q <= '0;
    end else begin
      zf_q    <= zf_d;
      ie_q    <= ie_d;
      run_q   <= run_d;
      sel_q   <= sel_d;
      rdata_q <= rdata_d;
    end
  end

  assign bus_rdata = rdata_q;
  assign irq       = zf_q & ie_q;
endmodule

// File: rtl/tmr_checker.sv
module tmr_checker #(
  parameter int CNT_W = 8,
  parameter int PSC_W = 7
) (
  input logic             clk,
  input logic             rst_n,
  input logic             run,
  input logic             zf,
  input logic             ie,
  input logic             irq,
  input logic             cnt_wr,
  input logic             psc_wr,
  input logic             ctrl_wr,
  input logic [CNT_W-1:0] wdata,
  input logic [CNT_W-1:0] cnt,
  input logic [PSC_W-1:0] psc
);
  p_park_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !run |=> (psc == {PSC_W{1'b1}}));

  p_frozen_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (!run && !cnt_wr) |=> (cnt == $past(cnt)));

  p_step_one_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (!$past(cnt_wr) && (cnt != $past(cnt))) |-> (cnt == $past(cnt) - 1'b1));

  p_psc_step_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (run && $past(run) && !$past(psc_wr) && (psc != $past(psc))) |-> (psc == $past(psc) - 1'b1));

  p_load_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_wr |=> (cnt == $past(wdata)));

  p_zero_set_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ($rose(zf) && !$past(ctrl_wr)) |-> ((cnt == '0) && ($past(cnt) == CNT_W'(1))));

  p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (zf && !ctrl_wr) |=> zf);

  p_irq_gate_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> (ie && zf));
endmodule

bind prescaled_timer tmr_checker #(.CNT_W(CNT_W), .PSC_W(PSC_W)) u_chk (
  .clk(clk), .rst_n(rst_sync_n), .run(run_q), .zf(zf_q), .ie(ie_q), .irq(irq),
  .cnt_wr(cnt_wr), .psc_wr(psc_wr), .ctrl_wr(ctrl_wr),
  .wdata(bus_wdata[CNT_W-1:0]), .cnt(cnt_q), .psc(psc_q)
);

// File: tb/prescaled_timer_tb.sv
module prescaled_timer_tb;
  localparam int CLK_PERIOD = 10;
  localparam int ADV = 12;

  typedef struct {
    logic [7:0] exp;
    logic [7:0] alt;
    string      tag;
  } exp_t;

  logic       clk, rst_n, bus_sel, bus_wr, irq;
  logic [1:0] bus_addr;
  logic [7:0] bus_wdata, bus_rdata;
  int n_chk, n_fail, cyc, t0;
  logic rd_seen;
  exp_t sb_q[$];

  prescaled_timer u_dut (
    .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .irq(irq)
  );

  initial clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  always @(posedge clk) begin
    cyc     <= cyc + 1;
    rd_seen <= bus_sel & ~bus_wr;
  end

  // monitor: pop expected read data and compare
  always @(negedge clk) begin
    if (rd_seen && sb_q.size() > 0) begin
      exp_t it;
      it = sb_q.pop_front();
      n_chk++;
      if (bus_rdata !== it.exp && bus_rdata !== it.alt) begin
        n_fail++;
        $display("FAIL %s: rdata=%h expected %h (or %h)", it.tag, bus_rdata, it.exp, it.alt);
      end
    end
  end

  task automatic chk(input logic act, input logic exp, input string tag);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual=%0b expected=%0b", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_sel = 1'b0; bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, input logic [7:0] e, input logic [7:0] alt, input string tag);
    exp_t it;
    it.exp = e; it.alt = alt; it.tag = tag;
    sb_q.push_back(it);
    bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_sel = 1'b0;
    @(negedge clk);
  endtask

  task automatic wait_irq(input int lo, input int hi, input string tag);
    int n;
    n = 0;
    while (!irq && n < hi + 10) begin
      @(negedge clk);
      n++;
    end
    n_chk++;
    if (n < lo || n > hi) begin
      n_fail++;
      $display("FAIL %s: irq after %0d cycles, expected %0d..%0d", tag, n, lo, hi);
    end
  endtask

  task automatic wait_off(input int o);
    while (((cyc - t0) % ADV) != o) @(negedge clk);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: run did not finish, expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    n_chk = 0; n_fail = 0; cyc = 0; t0 = 0;
    bus_sel = 0; bus_wr = 0; bus_addr = 0; bus_wdata = 0;
    rst_n = 1'b0;
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state, R10 map
    chk(irq, 1'b0, "R1 irq after reset");
    rd(2'd0, 8'hFF, 8'hFF, "R1 counter reset");
    rd(2'd1, 8'h7F, 8'h7F, "R1 prescaler reset");
    rd(2'd2, 8'h00, 8'h00, "R1 control reset");
    rd(2'd3, 8'h00, 8'h00, "R10 unused address");

    // R6 stopped: psc writes ignored, counter frozen but loadable
    wr(2'd1, 8'h15);
    rd(2'd1, 8'h7F, 8'h7F, "R6 prescaler write ignored");
    wr(2'd0, 8'h05);
    repeat (100) @(negedge clk);
    rd(2'd0, 8'h05, 8'h05, "R6 counter frozen");

    // R7 prescaler load while running
    wr(2'd2, 8'h20);
    wr(2'd1, 8'h40);
    rd(2'd1, 8'h40, 8'h3F, "R7 prescaler load");

    // R10 control bits 4:3 read zero
    wr(2'd2, 8'hFF);
    rd(2'd2, 8'hE7, 8'hE7, "R10 control layout");

    // R3 tap code 0, R5 irq
    wr(2'd2, 8'h60);
    wr(2'd0, 8'h04);
    wait_irq(35, 50, "R3 code0 timing");
    t0 = cyc;
    chk(irq, 1'b1, "R5 irq with flag and enable");

    // phase known: R2 prescaler cadence
    wr(2'd1, 8'h40);
    wait_off(5);
    repeat (2 * ADV) @(negedge clk);
    rd(2'd1, 8'h3E, 8'h3E, "R2 prescaler steps per advance");

    // R9 software clear beats hardware set
    wr(2'd2, 8'h60);
    wr(2'd0, 8'h01);
    wait_off(ADV - 1);
    wr(2'd2, 8'h60);
    rd(2'd2, 8'h60, 8'h60, "R9 clear beats set");
    rd(2'd0, 8'h00, 8'h00, "R4 counter reached zero");
    chk(irq, 1'b0, "R5 irq low after clear");

    // R4 wrap does not set the flag
    wait_off(ADV - 1);
    @(negedge clk);
    rd(2'd0, 8'hFF, 8'hFF, "R4 wrap to FF");
    rd(2'd2, 8'h60, 8'h60, "R4 no flag on wrap");

    // R8 write beats step
    wait_off(ADV - 1);
    wr(2'd0, 8'h50);
    rd(2'd0, 8'h50, 8'h50, "R8 write beats step");

    // R5 enable gating, R9 sticky flag
    wr(2'd2, 8'hA0);
    chk(irq, 1'b0, "R5 irq masked");
    repeat (30) @(negedge clk);
    rd(2'd2, 8'hA0, 8'hA0, "R9 flag sticky");
    wr(2'd2, 8'hE0);
    chk(irq, 1'b1, "R5 irq enabled");
    wr(2'd2, 8'h60);
    chk(irq, 1'b0, "R9 flag cleared by write");

    // R3 tap code 2 (factor 4)
    wr(2'd2, 8'h62);
    wr(2'd0, 8'h03);
    wait_irq(90, 150, "R3 code2 timing");

    // R3 tap code 7 (factor 128)
    wr(2'd2, 8'h67);
    wr(2'd0, 8'h03);
    wait_irq(3000, 4620, "R3 code7 timing");

    repeat (4) @(negedge clk);
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule